// File: doc/BRIEF.md
# Address Translation Request Front-End

This block sits between a memory-access source and the translation lookaside buffer. It takes one request at a time. Each request carries a virtual address, a request kind and a snapshot of the system control bits. The block settles the request's physical address, its cacheability and its shareability, and reports whether the request was aborted. Two cases are resolved before any lookup. A clear-exclusive request completes at once with address zero. With translation disabled, the address passes through unchanged and cacheability is derived from the remap attribute fields.

With translation enabled, the block looks up the TLB. A hit completes the request. A miss on a prefetch ends in a prefetch-miss abort and never starts a walk. Any other miss hands the address to an external table walker and holds its request line until the walker answers. A walker fault ends the request. A walker success is followed by a second lookup, whose result is final. The TLB answers combinationally in the cycle the block drives its lookup strobe.

The control is a five-state machine: idle, lookup, walk-wait, relookup and done. It drives a registered datapath through a small set of load strobes. Only one request is in flight at a time, and new requests are stalled until the result has been presented.

Top module: `xlateFront`

## Requirements
- R1: `reqReady` is high only while the block is idle. A request is taken on a clock edge where `reqValid` and `reqReady` are both high. While a request is in flight, `reqReady` stays low and changes on `reqValid`, `reqVaddr` or `reqKind` have no effect on its result.
- R2: A request of kind 4 (clear-exclusive) gives `respValid` in the cycle after acceptance with `respPaddr` = 0, `respUncache` = 1, `respShare` = 0 and no abort or fault. This holds whether translation is on or off, and the block makes no TLB lookup and no walk for it.
- R3: With `ctlMmuOn` low at acceptance and a kind other than 4, the result appears in the cycle after acceptance with `respPaddr` equal to the virtual address and `respShare` = 1. There is no lookup, no walk and no abort, and a prefetch is treated the same way.
- R4: In the R3 case, with `ctlRemapOn` low, `respUncache` is 1.
- R5: In the R3 case, with `ctlRemapOn` high, `respUncache` is 1 if inner field 0 is zero, outer field 0 is zero, type field 0 is not 2, or the cache enable that applies to the request kind (see R6) is low. Otherwise it is 0.
- R6: With translation on and a lookup hit, `respPaddr` = `tlbPaddr` and `respShare` = `tlbShare`. `respUncache` is 1 when the entry is non-cacheable or when the applicable cache enable captured at acceptance is low. A fetch (kind 0) uses `ctlIcacheOn`. Every other kind (1 read, 2 write, 3 prefetch, and the unused codes 5 to 7 taken as read) uses `ctlDcacheOn`.
- R7: A lookup miss on a prefetch (kind 3) completes with `respPfAbort` = 1 and zero address and attributes. `walkReq` is never raised for it.
- R8: A lookup miss on any other kind raises `walkReq`, with `walkVaddr` set to the request address, and holds it until `walkDone`. After a `walkDone` without fault, the block looks up the TLB a second time and takes its result from that second lookup.
- R9: `walkDone` with `walkFault` high ends the request with `respWalkFault` = 1 and zero address and attributes, and no second lookup.
- R10: A miss on the second lookup ends the request with `respWalkFault` = 1.
- R11: `respValid` is high for exactly one cycle per accepted request, and the block is ready again in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Block idle, request taken this edge |
| reqVaddr | input | VA_W | Virtual address |
| reqKind | input | 3 | 0 fetch, 1 read, 2 write, 3 prefetch, 4 clear-exclusive |
| ctlMmuOn | input | 1 | Translation enable |
| ctlIcacheOn | input | 1 | Instruction cache enable |
| ctlDcacheOn | input | 1 | Data cache enable |
| ctlRemapOn | input | 1 | Attribute remap enable |
| remapInner0 | input | ATTR_W | Inner attribute field 0 |
| remapOuter0 | input | ATTR_W | Outer attribute field 0 |
| remapType0 | input | TYPE_W | Memory type field 0 |
| tlbLookup | output | 1 | TLB lookup strobe |
| tlbVaddr | output | VA_W | Address being looked up |
| tlbHit | input | 1 | Lookup hit (combinational answer) |
| tlbPaddr | input | PA_W | Physical address of the hit |
| tlbNonCache | input | 1 | Hit entry is non-cacheable |
| tlbShare | input | 1 | Hit entry is shareable |
| walkReq | output | 1 | Table walk requested, held until done |
| walkVaddr | output | VA_W | Address to walk |
| walkDone | input | 1 | Walker finished |
| walkFault | input | 1 | Walker finished with a fault |
| respValid | output | 1 | Result valid, one cycle |
| respPaddr | output | PA_W | Physical address |
| respUncache | output | 1 | Access is uncacheable |
| respShare | output | 1 | Access is shareable |
| respPfAbort | output | 1 | Prefetch-miss abort |
| respWalkFault | output | 1 | Walk or relookup fault |

## Verification
The bench targets the remap cacheability rule one field at a time: a good inner field with a bad outer field, a bad type field, and a fully good triple with each cache enable low. A design that tested only part of the rule would mark such accesses cacheable. It also drives prefetch misses and checks that no walk starts and no second lookup happens; a design that filled on prefetch would show a walk request. Walker faults, and second lookups that still miss, are checked to end in a fault and not in a loop or a stale hit. Throughout every in-flight request the bench changes the request inputs, so a design that sampled them late or accepted a second request would return a wrong address.

// File: rtl/xlate_pkg.sv
package xlate_pkg;

  localparam logic [2:0] KIND_FETCH    = 3'd0;
  localparam logic [2:0] KIND_READ     = 3'd1;
  localparam logic [2:0] KIND_WRITE    = 3'd2;
  localparam logic [2:0] KIND_PREFETCH = 3'd3;
  localparam logic [2:0] KIND_CLREX    = 3'd4;

  localparam int unsigned REMAP_NORMAL_TYPE = 2;

  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_LOOKUP    = 3'd1,
    ST_WALK_WAIT = 3'd2,
    ST_RELOOKUP  = 3'd3,
    ST_DONE      = 3'd4
  } xlateState_t;

  // Load strobes from control to datapath
  typedef struct packed {
    logic capture;      // latch request fields
    logic loadSpecial;  // result from the pre-lookup path
    logic loadHit;      // result from the TLB hit
    logic loadPfAbort;  // prefetch-miss abort
    logic loadFault;    // walk fault or relookup miss
  } dpStrobe_t;

endpackage

// File: rtl/xlateCtrl.sv
module xlateCtrl
  import xlate_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic [2:0] reqKind,
  input  logic      ctlMmuOn,
  input  logic      tlbHit,
  input  logic      walkDone,
  input  logic      walkFault,
  input  logic      capIsPrefetch,
  output logic      reqReady,
  output logic      tlbLookup,
  output logic      walkReq,
  output logic      respValid,
  output dpStrobe_t strobe
);

  xlateState_t state, stateNext;
  logic specialPath;

  assign specialPath = (reqKind == KIND_CLREX) || !ctlMmuOn;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    reqReady  = 1'b0;
    tlbLookup = 1'b0;
    walkReq   = 1'b0;
    respValid = 1'b0;
    unique case (state)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          strobe.capture = 1'b1;
          if (specialPath) begin
            strobe.loadSpecial = 1'b1;
            stateNext = ST_DONE;
          end else begin
            stateNext = ST_LOOKUP;
          end
        end
      end
      ST_LOOKUP: begin
        tlbLookup = 1'b1;
        if (tlbHit) begin
          strobe.loadHit = 1'b1;
          stateNext = ST_DONE;
        end else if (capIsPrefetch) begin
          strobe.loadPfAbort = 1'b1;
          stateNext = ST_DONE;
        end else begin
          stateNext = ST_WALK_WAIT;
        end
      end
      ST_WALK_WAIT: begin
        walkReq = 1'b1;
        if (walkDone) begin
          if (walkFault) begin
            strobe.loadFault = 1'b1;
            stateNext = ST_DONE;
          end else begin
            stateNext = ST_RELOOKUP;
          end
        end
      end
      ST_RELOOKUP: begin
        tlbLookup = 1'b1;
        if (tlbHit) strobe.loadHit = 1'b1;
        else        strobe.loadFault = 1'b1;
        stateNext = ST_DONE;
      end
      ST_DONE: begin
        respValid = 1'b1;
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

endmodule

// File: rtl/xlateDatapath.sv
module xlateDatapath
  import xlate_pkg::*;
#(
  parameter int unsigned VA_W   = 32,
  parameter int unsigned PA_W   = 32,
  parameter int unsigned ATTR_W = 2,
  parameter int unsigned TYPE_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [VA_W-1:0]   reqVaddr,
  input  logic [2:0]        reqKind,
  input  logic              ctlIcacheOn,
  input  logic              ctlDcacheOn,
  input  logic              ctlRemapOn,
  input  logic [ATTR_W-1:0] remapInner0,
  input  logic [ATTR_W-1:0] remapOuter0,
  input  logic [TYPE_W-1:0] remapType0,
  input  logic [PA_W-1:0]   tlbPaddr,
  input  logic              tlbNonCache,
  input  logic              tlbShare,
  output logic [VA_W-1:0]   capVaddr,
  output logic              capIsPrefetch,
  output logic [PA_W-1:0]   respPaddr,
  output logic              respUncache,
  output logic              respShare,
  output logic              respPfAbort,
  output logic              respWalkFault
);

  localparam logic [TYPE_W-1:0] NormalType = TYPE_W'(REMAP_NORMAL_TYPE);

  logic [2:0] capKind;
  logic       capIcache, capDcache;
  logic       liveCacheOff, capCacheOff, remapUncache;
  logic [PA_W-1:0] specPaddr;
  logic       specUncache, specShare;

  // Fetches follow the instruction cache enable, everything else the data one
  assign liveCacheOff = (reqKind == KIND_FETCH) ? !ctlIcacheOn : !ctlDcacheOn;
  assign capCacheOff  = (capKind == KIND_FETCH) ? !capIcache   : !capDcache;
  assign capIsPrefetch = (capKind == KIND_PREFETCH);

  assign remapUncache = !ctlRemapOn
                      || (remapInner0 == '0)
                      || (remapOuter0 == '0)
                      || (remapType0 != NormalType);

  always_comb begin
    if (reqKind == KIND_CLREX) begin
      specPaddr   = '0;
      specUncache = 1'b1;
      specShare   = 1'b0;
    end else begin
      specPaddr   = PA_W'(reqVaddr);
      specUncache = liveCacheOff || remapUncache;
      specShare   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capVaddr  <= '0;
      capKind   <= KIND_READ;
      capIcache <= 1'b0;
      capDcache <= 1'b0;
    end else if (strobe.capture) begin
      capVaddr  <= reqVaddr;
      capKind   <= reqKind;
      capIcache <= ctlIcacheOn;
      capDcache <= ctlDcacheOn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      respPaddr     <= '0;
      respUncache   <= 1'b0;
      respShare     <= 1'b0;
      respPfAbort   <= 1'b0;
      respWalkFault <= 1'b0;
    end else if (strobe.loadSpecial) begin
      respPaddr     <= specPaddr;
      respUncache   <= specUncache;
      respShare     <= specShare;
      respPfAbort   <= 1'b0;
      respWalkFault <= 1'b0;
    end else if (strobe.loadHit) begin
      respPaddr     <= tlbPaddr;
      respUncache   <= tlbNonCache || capCacheOff;
      respShare     <= tlbShare;
      respPfAbort   <= 1'b0;
      respWalkFault <= 1'b0;
    end else if (strobe.loadPfAbort || strobe.loadFault) begin
      respPaddr     <= '0;
      respUncache   <= 1'b0;
      respShare     <= 1'b0;
      respPfAbort   <= strobe.loadPfAbort;
      respWalkFault <= strobe.loadFault;
    end
  end

endmodule

// File: rtl/xlateFront.sv
module xlateFront
  import xlate_pkg::*;
#(
  parameter int unsigned VA_W   = 32,
  parameter int unsigned PA_W   = 32,
  parameter int unsigned ATTR_W = 2,
  parameter int unsigned TYPE_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [VA_W-1:0]   reqVaddr,
  input  logic [2:0]        reqKind,
  input  logic              ctlMmuOn,
  input  logic              ctlIcacheOn,
  input  logic              ctlDcacheOn,
  input  logic              ctlRemapOn,
  input  logic [ATTR_W-1:0] remapInner0,
  input  logic [ATTR_W-1:0] remapOuter0,
  input  logic [TYPE_W-1:0] remapType0,
  output logic              tlbLookup,
  output logic [VA_W-1:0]   tlbVaddr,
  input  logic              tlbHit,
  input  logic [PA_W-1:0]   tlbPaddr,
  input  logic              tlbNonCache,
  input  logic              tlbShare,
  output logic              walkReq,
  output logic [VA_W-1:0]   walkVaddr,
  input  logic              walkDone,
  input  logic              walkFault,
  output logic              respValid,
  output logic [PA_W-1:0]   respPaddr,
  output logic              respUncache,
  output logic              respShare,
  output logic              respPfAbort,
  output logic              respWalkFault
);

  dpStrobe_t       strobe;
  logic            capIsPrefetch;
  logic [VA_W-1:0] capVaddr;

  assign tlbVaddr  = capVaddr;
  assign walkVaddr = capVaddr;

  xlateCtrl u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .reqValid      (reqValid),
    .reqKind       (reqKind),
    .ctlMmuOn      (ctlMmuOn),
    .tlbHit        (tlbHit),
    .walkDone      (walkDone),
    .walkFault     (walkFault),
    .capIsPrefetch (capIsPrefetch),
    .reqReady      (reqReady),
    .tlbLookup     (tlbLookup),
    .walkReq       (walkReq),
    .respValid     (respValid),
    .strobe        (strobe)
  );

  xlateDatapath #(
    .VA_W   (VA_W),
    .PA_W   (PA_W),
    .ATTR_W (ATTR_W),
    .TYPE_W (TYPE_W)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .reqVaddr      (reqVaddr),
    .reqKind       (reqKind),
    .ctlIcacheOn   (ctlIcacheOn),
    .ctlDcacheOn   (ctlDcacheOn),
    .ctlRemapOn    (ctlRemapOn),
    .remapInner0   (remapInner0),
    .remapOuter0   (remapOuter0),
    .remapType0    (remapType0),
    .tlbPaddr      (tlbPaddr),
    .tlbNonCache   (tlbNonCache),
    .tlbShare      (tlbShare),
    .capVaddr      (capVaddr),
    .capIsPrefetch (capIsPrefetch),
    .respPaddr     (respPaddr),
    .respUncache   (respUncache),
    .respShare     (respShare),
    .respPfAbort   (respPfAbort),
    .respWalkFault (respWalkFault)
  );

endmodule

// File: rtl/xlateFrontChk.sv
module xlateFrontChk #(
  parameter int unsigned VA_W = 32,
  parameter int unsigned PA_W = 32
) (
  input logic            clk,
  input logic            rstN,
  input logic            reqValid,
  input logic            reqReady,
  input logic [VA_W-1:0] reqVaddr,
  input logic [2:0]      reqKind,
  input logic            ctlMmuOn,
  input logic            tlbLookup,
  input logic            walkReq,
  input logic            walkDone,
  input logic            walkFault,
  input logic            respValid,
  input logic [PA_W-1:0] respPaddr,
  input logic            respUncache,
  input logic            respShare,
  input logic            respPfAbort,
  input logic            respWalkFault
);

  logic accept;
  logic pfPending;
  assign accept = reqValid && reqReady;

  // Tracks an accepted prefetch that has not yet completed
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                             pfPending <= 1'b0;
    else if (accept && reqKind == 3'd3)    pfPending <= 1'b1;
    else if (respValid)                    pfPending <= 1'b0;
  end

  p_ready_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (!respValid && !walkReq && !tlbLookup));

  p_clrex_result_r2: assert property (@(posedge clk) disable iff (!rstN)
    (accept && reqKind == 3'd4) |=>
      (respValid && respPaddr == '0 && respUncache && !respPfAbort && !respWalkFault));

  p_mmu_off_r3: assert property (@(posedge clk) disable iff (!rstN)
    (accept && reqKind != 3'd4 && !ctlMmuOn) |=>
      (respValid && respPaddr == PA_W'($past(reqVaddr)) && respShare && !respPfAbort));

  p_pf_no_walk_r7: assert property (@(posedge clk) disable iff (!rstN)
    pfPending |-> !walkReq);

  p_walk_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (walkReq && !walkDone) |=> walkReq);

  p_walk_fault_end_r9: assert property (@(posedge clk) disable iff (!rstN)
    (walkReq && walkDone && walkFault) |=> (respValid && respWalkFault && !tlbLookup));

  p_resp_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    respValid |=> (!respValid && reqReady));

  p_one_outcome_r7: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> !(respPfAbort && respWalkFault));

endmodule

bind xlateFront xlateFrontChk #(.VA_W(VA_W), .PA_W(PA_W)) u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .reqValid      (reqValid),
  .reqReady      (reqReady),
  .reqVaddr      (reqVaddr),
  .reqKind       (reqKind),
  .ctlMmuOn      (ctlMmuOn),
  .tlbLookup     (tlbLookup),
  .walkReq       (walkReq),
  .walkDone      (walkDone),
  .walkFault     (walkFault),
  .respValid     (respValid),
  .respPaddr     (respPaddr),
  .respUncache   (respUncache),
  .respShare     (respShare),
  .respPfAbort   (respPfAbort),
  .respWalkFault (respWalkFault)
);

// File: tb/test_xlateFront.sv
`timescale 1ns/1ps
module test_xlateFront;

  localparam int unsigned VA_W = 32;
  localparam int unsigned PA_W = 32;
  localparam logic [31:0] PA_XOR = 32'hA5A5_0000;

  typedef struct packed {
    logic [2:0]  kind;
    logic [31:0] vaddr;
    logic        mmu, ic, dc, remap;
    logic [1:0]  inner, outer, mtype;
    logic        present, nonCache, share, wFault, fill;
  } scen_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic reqReady;
  logic [31:0] reqVaddr = '0;
  logic [2:0] reqKind = '0;
  logic ctlMmuOn = 1'b0, ctlIcacheOn = 1'b0, ctlDcacheOn = 1'b0, ctlRemapOn = 1'b0;
  logic [1:0] remapInner0 = '0, remapOuter0 = '0, remapType0 = '0;
  logic tlbLookup;
  logic [31:0] tlbVaddr;
  logic tlbHit, tlbNonCache, tlbShare;
  logic [31:0] tlbPaddr;
  logic walkReq;
  logic [31:0] walkVaddr;
  logic walkDone = 1'b0, walkFault = 1'b0;
  logic respValid;
  logic [31:0] respPaddr;
  logic respUncache, respShare, respPfAbort, respWalkFault;

  int checks = 0;
  int fails  = 0;
  int cycleCount = 0;
  int wDelay = 0;
  logic tlbPresent = 1'b0;
  scen_t cur;

  always #2 clk = ~clk;

  // TLB model: combinational answer
  assign tlbHit      = tlbLookup && tlbPresent;
  assign tlbPaddr    = tlbVaddr ^ PA_XOR;
  assign tlbNonCache = cur.nonCache;
  assign tlbShare    = cur.share;

  xlateFront #(.VA_W(VA_W), .PA_W(PA_W)) i_xlateFront (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqVaddr(reqVaddr), .reqKind(reqKind), .ctlMmuOn(ctlMmuOn),
    .ctlIcacheOn(ctlIcacheOn), .ctlDcacheOn(ctlDcacheOn), .ctlRemapOn(ctlRemapOn),
    .remapInner0(remapInner0), .remapOuter0(remapOuter0), .remapType0(remapType0),
    .tlbLookup(tlbLookup), .tlbVaddr(tlbVaddr), .tlbHit(tlbHit), .tlbPaddr(tlbPaddr),
    .tlbNonCache(tlbNonCache), .tlbShare(tlbShare), .walkReq(walkReq),
    .walkVaddr(walkVaddr), .walkDone(walkDone), .walkFault(walkFault),
    .respValid(respValid), .respPaddr(respPaddr), .respUncache(respUncache),
    .respShare(respShare), .respPfAbort(respPfAbort), .respWalkFault(respWalkFault)
  );

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic cacheOff(input scen_t s);
    return (s.kind == 3'd0) ? !s.ic : !s.dc;
  endfunction

  // Walker model
  initial begin
    forever begin
      @(negedge clk);
      if (walkDone) begin
        walkDone  = 1'b0;
        walkFault = 1'b0;
      end else if (walkReq) begin
        if (walkVaddr !== cur.vaddr) begin
          fails++; checks++;
          $display("FAIL R8 walkVaddr: actual %0h expected %0h", walkVaddr, cur.vaddr);
        end
        if (wDelay == 0) begin
          walkDone  = 1'b1;
          walkFault = cur.wFault;
          if (!cur.wFault && cur.fill) tlbPresent = 1'b1;
          wDelay = int'($urandom % 4);
        end else begin
          wDelay--;
        end
      end
    end
  end

  task automatic runReq(input scen_t s);
    logic [31:0] expPa;
    logic expUnc, expShr, expPf, expFlt;
    int expLook, expWalk, cycles, looks, walks;
    logic prevWalk, got;
    string tag, uncTag;
    logic [31:0] gotPa;
    logic gotUnc, gotShr, gotPf, gotFlt;

    // expected outcome from the requirements
    expPa = '0; expUnc = 0; expShr = 0; expPf = 0; expFlt = 0; expLook = 0; expWalk = 0;
    uncTag = "R6";
    if (s.kind == 3'd4) begin
      tag = "R2"; expUnc = 1; uncTag = "R2";
    end else if (!s.mmu) begin
      tag = "R3"; expPa = s.vaddr; expShr = 1;
      uncTag = s.remap ? "R5" : "R4";
      expUnc = cacheOff(s) || !s.remap || s.inner == 0 || s.outer == 0 || s.mtype != 2'd2;
    end else if (s.present) begin
      tag = "R6"; expPa = s.vaddr ^ PA_XOR; expShr = s.share;
      expUnc = s.nonCache || cacheOff(s); expLook = 1;
    end else if (s.kind == 3'd3) begin
      tag = "R7"; expPf = 1; expLook = 1; uncTag = "R7";
    end else if (s.wFault) begin
      tag = "R9"; expFlt = 1; expLook = 1; expWalk = 1; uncTag = "R9";
    end else if (s.fill) begin
      tag = "R8"; expPa = s.vaddr ^ PA_XOR; expShr = s.share;
      expUnc = s.nonCache || cacheOff(s); expLook = 2; expWalk = 1; uncTag = "R8";
    end else begin
      tag = "R10"; expFlt = 1; expLook = 2; expWalk = 1; uncTag = "R10";
    end

    @(negedge clk);
    cur = s;
    tlbPresent = s.present;
    wDelay = int'($urandom % 4);
    reqVaddr = s.vaddr; reqKind = s.kind;
    ctlMmuOn = s.mmu; ctlIcacheOn = s.ic; ctlDcacheOn = s.dc; ctlRemapOn = s.remap;
    remapInner0 = s.inner; remapOuter0 = s.outer; remapType0 = s.mtype;
    reqValid = 1'b1;
    chk("R1", "ready when idle", 64'(reqReady), 64'd1);
    @(posedge clk);
    cycles = 0; looks = 0; walks = 0; prevWalk = 0; got = 0;
    gotPa = '0; gotUnc = 0; gotShr = 0; gotPf = 0; gotFlt = 0;
    while (!got && cycles < 60) begin
      @(negedge clk);
      cycles++;
      // R1: busy-time inputs must not disturb the request in flight
      reqVaddr = $urandom;
      reqKind  = 3'($urandom % 8);
      if (tlbLookup) looks++;
      if (walkReq && !prevWalk) walks++;
      prevWalk = walkReq;
      if (respValid) begin
        got = 1;
        gotPa = respPaddr; gotUnc = respUncache; gotShr = respShare;
        gotPf = respPfAbort; gotFlt = respWalkFault;
        reqValid = 1'b0;
      end else if (reqReady) begin
        chk("R1", "ready while busy", 64'(reqReady), 64'd0);
      end
    end
    chk(tag, "completed", 64'(got), 64'd1);
    chk(tag, "paddr", 64'(gotPa), 64'(expPa));
    chk(uncTag, "uncache", 64'(gotUnc), 64'(expUnc));
    chk(tag, "share", 64'(gotShr), 64'(expShr));
    chk(tag, "pfAbort", 64'(gotPf), 64'(expPf));
    chk(tag, "walkFault", 64'(gotFlt), 64'(expFlt));
    chk(tag, "lookups", 64'(looks), 64'(expLook));
    chk(tag, "walks", 64'(walks), 64'(expWalk));
    if (expLook == 0) chk(tag, "latency", 64'(cycles), 64'd1);
    @(negedge clk);
    chk("R11", "resp one cycle", 64'(respValid), 64'd0);
    chk("R11", "ready after resp", 64'(reqReady), 64'd1);
  endtask

  function automatic scen_t base();
    scen_t s;
    s = '0;
    s.kind = 3'd1; s.vaddr = 32'h0000_1230; s.mmu = 1; s.ic = 1; s.dc = 1;
    s.remap = 1; s.inner = 2'd1; s.outer = 2'd1; s.mtype = 2'd2;
    s.present = 1; s.share = 1;
    return s;
  endfunction

  // Watchdog
  initial begin
    forever begin
      @(posedge clk);
      cycleCount++;
      if (cycleCount > 150000) begin
        fails++; checks++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycleCount);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    scen_t s;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "reset ready", 64'(reqReady), 64'd1);
    chk("R11", "reset respValid", 64'(respValid), 64'd0);
    chk("R8", "reset walkReq", 64'(walkReq), 64'd0);
    rstN = 1'b1;

    // Directed corner cases
    s = base(); s.kind = 3'd4; runReq(s);                    // R2 mmu on
    s = base(); s.kind = 3'd4; s.mmu = 0; runReq(s);         // R2 mmu off
    s = base(); s.mmu = 0; s.remap = 0; runReq(s);           // R4
    s = base(); s.mmu = 0; runReq(s);                        // R5 cacheable
    s = base(); s.mmu = 0; s.inner = 0; runReq(s);           // R5
    s = base(); s.mmu = 0; s.outer = 0; runReq(s);           // R5
    s = base(); s.mmu = 0; s.mtype = 2'd3; runReq(s);        // R5
    s = base(); s.mmu = 0; s.dc = 0; runReq(s);              // R5 data cache off
    s = base(); s.mmu = 0; s.kind = 3'd0; s.ic = 0; runReq(s); // R5 fetch
    s = base(); s.mmu = 0; s.kind = 3'd3; s.present = 0; runReq(s); // R3 prefetch
    s = base(); s.kind = 3'd0; s.ic = 0; runReq(s);          // R6 fetch ic off
    s = base(); s.kind = 3'd0; s.dc = 0; runReq(s);          // R6 fetch dc off
    s = base(); s.kind = 3'd2; s.nonCache = 1; runReq(s);    // R6 non-cacheable
    s = base(); s.kind = 3'd6; s.dc = 0; runReq(s);          // R6 unused code as read
    s = base(); s.kind = 3'd3; s.present = 0; runReq(s);     // R7
    s = base(); s.present = 0; s.fill = 1; runReq(s);        // R8
    s = base(); s.present = 0; s.wFault = 1; runReq(s);      // R9
    s = base(); s.kind = 3'd2; s.present = 0; runReq(s);     // R10

    // Constrained random mix
    for (int i = 0; i < 400; i++) begin
      s = '0;
      s.kind = 3'($urandom % 8);
      s.vaddr = $urandom;
      s.mmu = ($urandom % 4) != 0;
      s.ic = $urandom; s.dc = $urandom; s.remap = $urandom;
      s.inner = $urandom; s.outer = $urandom;
      s.mtype = (($urandom % 2) == 0) ? 2'd2 : 2'($urandom);
      s.present = $urandom; s.nonCache = $urandom; s.share = $urandom;
      s.wFault = ($urandom % 4) == 0;
      s.fill = ($urandom % 4) != 0;
      runReq(s);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule